// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It watches a free-running count supplied from outside and keeps a channel value in two copies: a bus-side preload copy that every read and write touches, and a working copy that the rest of the channel uses. In compare mode the working copy is matched against the count. A selectable rule turns the greater-than and equal flags into a reference waveform. That waveform then feeds two lanes, main and complementary. Each lane has dead-time delay on its rising edge, its own polarity and its own enable, and a master enable gates both.

In capture mode the data moves the other way. A rising edge on the capture input stores the count in the working copy, and one cycle later that value reaches the preload copy, where the bus can read it. The preload copy reaches the working copy in one of two ways. With buffering on, it is copied only on a one-cycle update pulse. With buffering off, a write goes straight through to both copies.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset both copies of the channel value are zero, the reference is low, and the dead-time count is zero.
- R2: A write stores its data in the preload copy, and the read port shows the preload copy on the next cycle. In capture mode a pending capture copy takes priority over a write in the same cycle.
- R3: In compare mode with buffering off, a write also loads the working copy on the same edge. With buffering on, the working copy changes only on a cycle with the update pulse high, and it then takes the preload value held before that edge.
- R4: In capture mode (capture select = 1), a capture-input sample of 1 that follows a sample of 0 loads the working copy with the count on that edge. The preload copy takes the working copy on the next edge. The reference holds while capture mode is selected.
- R5: Only the working copy is compared with the count. The reference rule sees two flags: count greater than working, and count equal to working.
- R6: Mode 0 holds the reference. Mode 1 sets it when the count equals the working value. Mode 2 clears it on equality. Mode 3 toggles it on equality.
- R7: Mode 4 drives the reference low and mode 5 drives it high. Mode 6 makes it high while count < working, and mode 7 makes it low while count < working. Modes 8 to 15 hold.
- R8: The main lane is active when the reference is high and the dead-time count has reached the 8-bit dead-time value. The complementary lane is active under the same count condition when the reference is low. The count restarts at 0 on every reference change and then rises by one per cycle until it equals the dead-time value. The two lanes are never active together.
- R9: Each output equals its lane's active value XOR that output's polarity bit.
- R10: When the master enable or the output's own enable is 0, the output is driven to its polarity bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CW | External counter value |
| wr_en_i | input | 1 | Write strobe for the channel value |
| wr_data_i | input | CW | Write data |
| rd_data_o | output | CW | Preload copy, as read by the bus |
| preload_en_i | input | 1 | 1 = buffered transfer on the update pulse |
| upd_i | input | 1 | One-cycle update pulse |
| cap_mode_i | input | 1 | 1 = capture, 0 = compare |
| cap_in_i | input | 1 | Capture input; a rising edge triggers a capture |
| mode_i | input | 4 | Reference rule select |
| dead_i | input | DTW | Dead-time in clock cycles |
| moe_i | input | 1 | Master output enable |
| en_main_i | input | 1 | Main output enable |
| en_comp_i | input | 1 | Complementary output enable |
| pol_main_i | input | 1 | Main output polarity (1 inverts) |
| pol_comp_i | input | 1 | Complementary output polarity (1 inverts) |
| ref_o | output | 1 | Reference waveform |
| out_main_o | output | 1 | Main output |
| out_comp_o | output | 1 | Complementary output |

## Verification
If the working copy takes a bad value, the fault stays hidden until the count passes it. It then shows on the reference one cycle later, as a match edge or a PWM boundary in the wrong place. A bad preload copy appears on the read port in the cycle after it forms, or after the next update, when it moves into the working copy. A wrong dead-time count moves the rising edge of an output by whole cycles, or makes the two lanes overlap. That is why the bench compares all four outputs against its model after every clock.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
    localparam logic [3:0] MODE_FROZEN = 4'd0;
    localparam logic [3:0] MODE_SET    = 4'd1;
    localparam logic [3:0] MODE_CLR    = 4'd2;
    localparam logic [3:0] MODE_TOG    = 4'd3;
    localparam logic [3:0] MODE_LOW    = 4'd4;
    localparam logic [3:0] MODE_HIGH   = 4'd5;
    localparam logic [3:0] MODE_PWM_HI = 4'd6;
    localparam logic [3:0] MODE_PWM_LO = 4'd7;

    localparam int LANE_MAIN = 0;
    localparam int LANE_COMP = 1;
    localparam int NUM_LANES = 2;

    typedef struct packed {
        logic gt;
        logic eq;
    } cmp_flags_t;
endpackage

// File: rtl/cc_buffer.sv
module cc_buffer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic          preload_en_i,
    input  logic          upd_i,
    input  logic          cap_mode_i,
    input  logic          cap_in_i,
    output logic [CW-1:0] preload_o,
    output logic [CW-1:0] work_o
);
    typedef struct packed {
        logic [CW-1:0] pre;
        logic [CW-1:0] work;
        logic          copy;
        logic          cap_prev;
    } buf_t;

    buf_t q, d;
    logic cap_edge;

    always_comb begin
        d        = q;
        cap_edge = cap_mode_i && cap_in_i && !q.cap_prev;
        d.cap_prev = cap_in_i;
        d.copy     = cap_edge;
        if (q.copy)       d.pre = q.work;
        else if (wr_en_i) d.pre = wr_data_i;
        if (cap_mode_i) begin
            if (cap_edge) d.work = cnt_i;
        end else if (!preload_en_i && wr_en_i) begin
            d.work = wr_data_i;
        end else if (preload_en_i && upd_i) begin
            d.work = q.pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign preload_o = q.pre;
    assign work_o    = q.work;

    // R3
    work_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_i && !preload_en_i && wr_en_i) |=> work_o == $past(wr_data_i));
    // R3
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_i && preload_en_i && !upd_i) |=> $stable(work_o));
    // R4
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && cap_in_i && !q.cap_prev) |=> work_o == $past(cnt_i));
    // R4
    cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.copy |=> preload_o == $past(work_o));
endmodule

// File: rtl/cc_ref_gen.sv
module cc_ref_gen
    import tmr_cc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] work_i,
    input  logic          cap_mode_i,
    input  logic [3:0]    mode_i,
    output logic          ref_o,
    output logic          ref_next_o
);
    cmp_flags_t flags;
    logic ref_d, ref_q, cnt_lt;

    always_comb begin
        flags.gt = cnt_i > work_i;
        flags.eq = cnt_i == work_i;
        cnt_lt   = !flags.gt && !flags.eq;
        ref_d    = ref_q;
        if (!cap_mode_i) begin
            case (mode_i)
                MODE_SET:    if (flags.eq) ref_d = 1'b1;
                MODE_CLR:    if (flags.eq) ref_d = 1'b0;
                MODE_TOG:    if (flags.eq) ref_d = !ref_q;
                MODE_LOW:    ref_d = 1'b0;
                MODE_HIGH:   ref_d = 1'b1;
                MODE_PWM_HI: ref_d = cnt_lt;
                MODE_PWM_LO: ref_d = !cnt_lt;
                default:     ref_d = ref_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end

    assign ref_o      = ref_q;
    assign ref_next_o = ref_d;

    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_i && mode_i == MODE_LOW) |=> !ref_o);
    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_i && mode_i == MODE_HIGH) |=> ref_o);
    // R4
    cap_hold_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode_i |=> $stable(ref_o));
endmodule

// File: rtl/cc_deadtime.sv
module cc_deadtime
    import tmr_cc_pkg::*;
#(
    parameter int DTW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_i,
    input  logic                 ref_next_i,
    input  logic [DTW-1:0]       dead_i,
    input  logic                 moe_i,
    input  logic [NUM_LANES-1:0] en_i,
    input  logic [NUM_LANES-1:0] pol_i,
    output logic [NUM_LANES-1:0] out_o
);
    logic [DTW-1:0]       dt_d, dt_q;
    logic                 settled;
    logic [NUM_LANES-1:0] lane_act;

    always_comb begin
        if (ref_next_i != ref_i) dt_d = '0;
        else if (dt_q < dead_i)  dt_d = dt_q + 1'b1;
        else                     dt_d = dt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dt_q <= '0;
        else        dt_q <= dt_d;
    end

    assign settled = dt_q >= dead_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic ACT_LVL = (g == LANE_MAIN);
        assign lane_act[g] = (ref_i == ACT_LVL) && settled;
        assign out_o[g]    = (moe_i && en_i[g]) ? (lane_act[g] ^ pol_i[g]) : pol_i[g];
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lane_act[LANE_MAIN] && lane_act[LANE_COMP]));
    // R8
    dead_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_i) && dead_i != '0) |-> !lane_act[LANE_MAIN]);
    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !moe_i |-> out_o == pol_i);
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
    import tmr_cc_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_i,
    input  logic           wr_en_i,
    input  logic [CW-1:0]  wr_data_i,
    output logic [CW-1:0]  rd_data_o,
    input  logic           preload_en_i,
    input  logic           upd_i,
    input  logic           cap_mode_i,
    input  logic           cap_in_i,
    input  logic [3:0]     mode_i,
    input  logic [DTW-1:0] dead_i,
    input  logic           moe_i,
    input  logic           en_main_i,
    input  logic           en_comp_i,
    input  logic           pol_main_i,
    input  logic           pol_comp_i,
    output logic           ref_o,
    output logic           out_main_o,
    output logic           out_comp_o
);
    logic [CW-1:0]        work;
    logic                 ref_next;
    logic [NUM_LANES-1:0] outs;

    cc_buffer #(.CW(CW)) u_buf (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .preload_en_i(preload_en_i), .upd_i(upd_i),
        .cap_mode_i(cap_mode_i), .cap_in_i(cap_in_i),
        .preload_o(rd_data_o), .work_o(work)
    );

    cc_ref_gen #(.CW(CW)) u_ref (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .work_i(work),
        .cap_mode_i(cap_mode_i), .mode_i(mode_i),
        .ref_o(ref_o), .ref_next_o(ref_next)
    );

    cc_deadtime #(.DTW(DTW)) u_dt (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_o), .ref_next_i(ref_next),
        .dead_i(dead_i), .moe_i(moe_i),
        .en_i({en_comp_i, en_main_i}), .pol_i({pol_comp_i, pol_main_i}),
        .out_o(outs)
    );

    assign out_main_o = outs[LANE_MAIN];
    assign out_comp_o = outs[LANE_COMP];
endmodule

// File: tb/tmr_cc_channel_tb.sv
`timescale 1ns/1ps
module tmr_cc_channel_tb;
    localparam int CW = 16;
    localparam int DTW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CW-1:0] cnt_i = '0, wr_data_i = '0, rd_data_o;
    logic wr_en_i = 0, preload_en_i = 0, upd_i = 0, cap_mode_i = 0, cap_in_i = 0;
    logic [3:0] mode_i = 4'd0;
    logic [DTW-1:0] dead_i = '0;
    logic moe_i = 0, en_main_i = 0, en_comp_i = 0, pol_main_i = 0, pol_comp_i = 0;
    logic ref_o, out_main_o, out_comp_o;

    always #2.5 clk = ~clk;

    tmr_cc_channel #(.CW(CW), .DTW(DTW)) u_dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model state
    logic [CW-1:0] m_pre = '0, m_wrk = '0;
    logic m_cp = 0, m_prev = 0, m_ref = 0;
    logic [DTW-1:0] m_dtc = '0;

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic ref_rule(logic [3:0] m, logic r, logic [CW-1:0] c, logic [CW-1:0] w);
        case (m)
            4'd1: return (c == w) ? 1'b1 : r;   // R6
            4'd2: return (c == w) ? 1'b0 : r;
            4'd3: return (c == w) ? !r : r;
            4'd4: return 1'b0;                   // R7
            4'd5: return 1'b1;
            4'd6: return c < w;
            4'd7: return !(c < w);
            default: return r;
        endcase
    endfunction

    function automatic logic out_exp(logic act_lvl, logic en, logic pol);
        logic act;
        act = (m_ref == act_lvl) && (m_dtc >= dead_i);  // R8
        return (moe_i && en) ? (act ^ pol) : pol;        // R9 R10
    endfunction

    task automatic compare_all();
        check("R2 R3 R4 read port", rd_data_o, m_pre);
        check("R5 R6 R7 reference", {15'd0, ref_o}, {15'd0, m_ref});
        check("R8 R9 R10 main out", {15'd0, out_main_o}, {15'd0, out_exp(1'b1, en_main_i, pol_main_i)});
        check("R8 R9 R10 comp out", {15'd0, out_comp_o}, {15'd0, out_exp(1'b0, en_comp_i, pol_comp_i)});
    endtask

    task automatic step();
        logic [CW-1:0] n_pre, n_wrk;
        logic edge_c, n_ref;
        logic [DTW-1:0] n_dtc;
        edge_c = cap_mode_i && cap_in_i && !m_prev;
        n_pre = m_cp ? m_wrk : (wr_en_i ? wr_data_i : m_pre);
        n_wrk = m_wrk;
        if (cap_mode_i) begin
            if (edge_c) n_wrk = cnt_i;
        end else if (!preload_en_i && wr_en_i) n_wrk = wr_data_i;
        else if (preload_en_i && upd_i) n_wrk = m_pre;
        n_ref = cap_mode_i ? m_ref : ref_rule(mode_i, m_ref, cnt_i, m_wrk);
        if (n_ref != m_ref) n_dtc = '0;
        else if (m_dtc < dead_i) n_dtc = m_dtc + 1'b1;
        else n_dtc = m_dtc;
        @(posedge clk);
        #1;
        m_pre = n_pre; m_wrk = n_wrk; m_cp = edge_c; m_prev = cap_in_i;
        m_ref = n_ref; m_dtc = n_dtc;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        #1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state with outputs gated
        check("R1 read after reset", rd_data_o, '0);
        check("R1 ref after reset", {15'd0, ref_o}, 16'd0);
        check("R1 main inactive", {15'd0, out_main_o}, 16'd0);
        rst_n = 1;
        step();

        // R3 buffered: write then no update -> working unchanged
        moe_i = 1; en_main_i = 1; en_comp_i = 1; mode_i = 4'd6; preload_en_i = 1;
        wr_en_i = 1; wr_data_i = 16'd10; step(); wr_en_i = 0;
        for (int i = 0; i < 12; i++) begin cnt_i = 16'(i); step(); end
        upd_i = 1; step(); upd_i = 0;          // R3 transfer
        for (int i = 0; i < 12; i++) begin cnt_i = 16'(i); step(); end
        // R8 dead-time with PWM
        dead_i = 8'd3;
        for (int i = 0; i < 24; i++) begin cnt_i = 16'(i % 16); step(); end
        // R9 polarity
        pol_main_i = 1; pol_comp_i = 1;
        for (int i = 0; i < 16; i++) begin cnt_i = 16'(i); step(); end
        // R10 gating
        moe_i = 0; step(); moe_i = 1; en_comp_i = 0; step(); en_comp_i = 1;
        // R4 capture
        cap_mode_i = 1; cnt_i = 16'h55; cap_in_i = 1; step(); step(); step();
        cap_in_i = 0; cnt_i = 16'h77; step(); cap_in_i = 1; step(); step();
        cap_mode_i = 0; cap_in_i = 0;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 40) == 0) begin
                mode_i = 4'($urandom_range(0, 15));
                preload_en_i = 1'($urandom);
                cap_mode_i = ($urandom_range(0, 5) == 0);
                dead_i = 8'($urandom_range(0, 6));
                moe_i = ($urandom_range(0, 7) != 0);
                en_main_i = ($urandom_range(0, 7) != 0);
                en_comp_i = ($urandom_range(0, 7) != 0);
                pol_main_i = 1'($urandom);
                pol_comp_i = 1'($urandom);
            end
            wr_en_i = ($urandom_range(0, 9) == 0);
            wr_data_i = 16'($urandom_range(0, 31));
            upd_i = ($urandom_range(0, 15) == 0);
            cap_in_i = ($urandom_range(0, 3) == 0);
            cnt_i = (cnt_i >= 16'd31) ? 16'd0 : cnt_i + 16'd1;
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule